// File: doc/BRIEF.md
# SMBus Control Register Slave

This block is a two-wire serial slave, compatible with SMBus byte and block transactions, that holds a small bank of 8-bit control registers. It listens on a fixed 7-bit address. It accepts byte write, byte read, block write and block read transfers. The command byte that follows the address decides two things: whether the transfer is indexed single-byte access or sequential block access, and, in byte mode, which register is touched.

SCL and SDA are oversampled on the system clock through synchronisers. START and STOP conditions and SCL edges are detected from the synchronised samples. SDA is driven open-drain: the block only ever pulls the line low. Every register bit is presented in parallel on `regs_o`, where the bits serve as output-enable and configuration lines for the surrounding chip. A value of 1 enables an output and 0 disables it. Register 1 bit 0 enables spread spectrum on the CPU clock PLL. Register 2 bit 0 is a control bit that removes the byte-count byte from block writes.

Top module: `smb_regbank`

## Requirements
- R1: After reset, register 0 reads 8'hFF, register 1 reads 8'hF7 (bit 3 clear), and register 2 reads 8'hFE (bits 7:1 set, bit 0 clear), so `regs_o` = 24'hFEF7FF. SDA is not driven.
- R2: Only the address byte 8'hD2 (write) or 8'hD3 (read), which is 7-bit address 7'h69 with R/W in bit 0, is acknowledged. Any other address is NACKed. Every byte that follows it is then ignored until the next START, and no register changes.
- R3: A byte write is START, D2, a command with bit 7 = 1 and the offset in bits 6:0, one data byte, and STOP. Each byte is ACKed, and the data lands in the addressed register.
- R4: A byte read is START, D2, a command with bit 7 = 1 and the offset, repeated START, D3, then one byte from the slave, MSB first. That byte equals the addressed register. The master then NACKs and sends STOP.
- R5: A byte-mode command whose offset is 3 or higher is NACKed, and no register is written.
- R6: A block write is START, D2, command 8'h00, a byte-count byte (ACKed, value ignored), then data bytes stored into register 0, 1, 2 in that order. A STOP after any whole byte leaves the registers not yet reached unchanged.
- R7: While register 2 bit 0 (`regs_o[16]`) is 1, a block write carries no byte-count byte: the first byte after the command goes to register 0.
- R8: A block read (D2, 8'h00, repeated START, D3) returns the count 8'h03 and then registers 0, 1 and 2 in order. It continues while the master ACKs. After the master NACKs, SDA stays released.
- R9: A block-mode command (bit 7 = 0) with any of bits 6:0 nonzero is NACKed.
- R10: In a block write, data bytes beyond register 2 are NACKed and not stored.
- R11: A STOP, even in the middle of a byte, returns the slave to idle with SDA released. The slave changes its SDA drive only while SCL is low.
- R12: Register k appears on `regs_o[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 24 | All register bits, register k in bits 8k+7:8k |

## Verification
The hardest situations to reach from the pins are a block write that runs past the last register and a block write with the byte-count byte switched off. Both depend on earlier state rather than on the transaction alone. The stimulus first drives a block write of four data bytes to show that the fourth is refused. It then sets the count-removal bit through an ordinary byte write and issues a block write without the count byte. Finally it clears the bit and shows that the count byte is expected again. A bare STOP in the middle of an address byte, followed by a normal read, covers recovery from an aborted transfer.

// File: rtl/smb_pkg.sv
package smb_pkg;

    // Top-level protocol state.
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RXACK,
        S_TX,
        S_TXACK,
        S_WAIT
    } smb_state_e;

    // Which byte of the transaction the receiver is collecting.
    typedef enum logic [2:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA,
        PH_RDGO
    } smb_phase_e;

endpackage

// File: rtl/smb_sync.sv
// Multi-flop synchroniser for one bus line; also returns the sample one
// stage older so edges can be found downstream.
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic prev_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], d_i};
    end

    assign q_o    = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/smb_events.sv
// Bus condition decoder working on synchronised samples.
module smb_events (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    // SDA moving while SCL stays high marks a bus condition.
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
// Bank of 8-bit control registers with one write port and parallel outputs.
module smb_regfile #(
    parameter int NUM_REGS = 3,
    parameter int IDX_W    = 2,
    parameter logic [NUM_REGS*8-1:0] RST_VAL = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [7:0]            wr_data_i,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= RST_VAL[g*8 +: 8];
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                val_q <= wr_data_i;
        end
        assign regs_o[g*8 +: 8] = val_q;
    end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 3,
    parameter logic [NUM_REGS*8-1:0] RST_VAL = 24'hFE_F7_FF,
    parameter int         SKIP_REG    = 2,
    parameter int         SKIP_BIT    = 0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam int PTR_W   = $clog2(NUM_REGS + 1);
    localparam int SKIP_IX = SKIP_REG * 8 + SKIP_BIT;

    typedef struct packed {
        smb_state_e       st;
        smb_phase_e       ph;
        logic [3:0]       nbit;
        logic [7:0]       sh;
        logic             ack;
        logic             blk;
        logic             cnt_pend;
        logic [PTR_W-1:0] ptr;
        logic             oe;
        logic             got_ack;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: S_IDLE, ph: PH_ADDR, nbit: 4'd0, sh: 8'h00, ack: 1'b0,
        blk: 1'b0, cnt_pend: 1'b0, ptr: '0, oe: 1'b0, got_ack: 1'b0
    };

    // ---------------- line sampling ----------------
    logic [1:0] line_in, line_s, line_p;
    assign line_in = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_i    (line_in[g]),
            .q_o    (line_s[g]),
            .prev_o (line_p[g])
        );
    end

    logic scl_s, scl_p, sda_s, sda_p;
    assign scl_s = line_s[0];
    assign scl_p = line_p[0];
    assign sda_s = line_s[1];
    assign sda_p = line_p[1];

    logic ev_rise, ev_fall, ev_start, ev_stop;
    smb_events u_events (
        .scl_s    (scl_s),
        .scl_p    (scl_p),
        .sda_s    (sda_s),
        .sda_p    (sda_p),
        .scl_rise (ev_rise),
        .scl_fall (ev_fall),
        .start_ev (ev_start),
        .stop_ev  (ev_stop)
    );

    // ---------------- register bank ----------------
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    smb_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (PTR_W),
        .RST_VAL  (RST_VAL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs_o)
    );

    function automatic logic [7:0] pick(input logic [PTR_W-1:0] p,
                                        input logic [NUM_REGS*8-1:0] v);
        logic [7:0] b;
        b = 8'hFF;
        for (int k = 0; k < NUM_REGS; k++)
            if (p == PTR_W'(k)) b = v[k*8 +: 8];
        return b;
    endfunction

    // ---------------- protocol engine ----------------
    ctl_t q, d;
    logic [7:0]       nxt_byte;
    logic [PTR_W-1:0] nxt_ptr;
    logic             nxt_cnt;
    logic             bus_idle;

    always_comb begin
        // Next byte to transmit: the count first in block mode, then registers.
        if (q.blk && q.cnt_pend) begin
            nxt_byte = 8'(NUM_REGS);
            nxt_ptr  = q.ptr;
            nxt_cnt  = 1'b0;
        end else begin
            nxt_byte = pick(q.ptr, regs_o);
            nxt_ptr  = (int'(q.ptr) < NUM_REGS) ? q.ptr + PTR_W'(1) : q.ptr;
            nxt_cnt  = q.cnt_pend;
        end

        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.ptr;
        wr_data = q.sh;

        if (ev_start) begin
            d.st   = S_RX;
            d.ph   = PH_ADDR;
            d.nbit = 4'd0;
            d.oe   = 1'b0;
        end else if (ev_stop) begin
            d.st   = S_IDLE;
            d.nbit = 4'd0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (ev_rise && q.nbit != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.nbit = q.nbit + 4'd1;
                    end else if (ev_fall && q.nbit == 4'd8) begin
                        d.nbit = 4'd0;
                        d.st   = S_RXACK;
                        d.ack  = 1'b0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.ack = 1'b1;
                                    d.ph  = q.sh[0] ? PH_RDGO : PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                if (q.sh[7]) begin
                                    d.blk      = 1'b0;
                                    d.cnt_pend = 1'b0;
                                    d.ph       = PH_DATA;
                                    if (int'(q.sh[6:0]) < NUM_REGS) begin
                                        d.ack = 1'b1;
                                        d.ptr = q.sh[PTR_W-1:0];
                                    end
                                end else begin
                                    d.blk      = 1'b1;
                                    d.cnt_pend = 1'b1;
                                    d.ptr      = '0;
                                    d.ack      = (q.sh[6:0] == 7'd0);
                                    d.ph       = regs_o[SKIP_IX] ? PH_DATA : PH_CNT;
                                end
                            end
                            PH_CNT: begin
                                d.ack = 1'b1;
                                d.ph  = PH_DATA;
                            end
                            PH_DATA: begin
                                if (int'(q.ptr) < NUM_REGS) begin
                                    wr_en = 1'b1;
                                    d.ack = 1'b1;
                                    d.ptr = q.ptr + PTR_W'(1);
                                end
                            end
                            default: ;
                        endcase
                        d.oe = d.ack;
                    end
                end
                S_RXACK: begin
                    if (ev_fall) begin
                        d.nbit = 4'd0;
                        if (!q.ack) begin
                            d.st = S_WAIT;
                            d.oe = 1'b0;
                        end else if (q.ph == PH_RDGO) begin
                            d.st       = S_TX;
                            d.sh       = nxt_byte;
                            d.ptr      = nxt_ptr;
                            d.cnt_pend = nxt_cnt;
                            d.oe       = ~nxt_byte[7];
                        end else begin
                            d.st = S_RX;
                            d.oe = 1'b0;
                        end
                    end
                end
                S_TX: begin
                    if (ev_rise && q.nbit != 4'd8) begin
                        d.nbit = q.nbit + 4'd1;
                    end else if (ev_fall) begin
                        if (q.nbit == 4'd8) begin
                            d.st = S_TXACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                S_TXACK: begin
                    if (ev_rise) begin
                        d.got_ack = ~sda_s;
                    end else if (ev_fall) begin
                        d.nbit = 4'd0;
                        if (q.got_ack) begin
                            d.st       = S_TX;
                            d.sh       = nxt_byte;
                            d.ptr      = nxt_ptr;
                            d.cnt_pend = nxt_cnt;
                            d.oe       = ~nxt_byte[7];
                        end else begin
                            d.st = S_WAIT;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;
    assign bus_idle = (q.st == S_IDLE);
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk #(
    parameter int NUM_REGS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sda_oe,
    input logic                  scl_s,
    input logic                  scl_p,
    input logic                  start_ev,
    input logic                  stop_ev,
    input logic                  wr_en,
    input logic [NUM_REGS*8-1:0] regs,
    input logic                  bus_idle
);
    // R11: a STOP always leaves SDA released.
    assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    // R11: drive changes only after SCL has gone low (or on a bus condition).
    assert_scl_high_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && $past(scl_p) && !$past(start_ev) && !$past(stop_ev))
        |-> $stable(sda_oe));

    // R2: an idle slave never touches the line.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> !sda_oe);

    // R5: registers move only on a write strobe.
    assert_hold_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R3: every stored byte is acknowledged.
    assert_write_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);
endmodule

bind smb_regbank smb_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .scl_s    (scl_s),
    .scl_p    (scl_p),
    .start_ev (ev_start),
    .stop_ev  (ev_stop),
    .wr_en    (wr_en),
    .regs     (regs_o),
    .bus_idle (bus_idle)
);

// File: tb/sim_smb_regbank.sv
module sim_smb_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_bus;
    logic [23:0] regs;
    logic [23:0] mdl;

    assign sda_bus = sda_m & ~sda_oe;

    smb_regbank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // {read, offset[6:0], data[7:0], expected command ACK}
    localparam logic [16:0] VEC [0:10] = '{
        {1'b1, 7'd0, 8'hFF, 1'b1},
        {1'b1, 7'd1, 8'hF7, 1'b1},
        {1'b1, 7'd2, 8'hFE, 1'b1},
        {1'b0, 7'd1, 8'hA5, 1'b1},
        {1'b1, 7'd1, 8'hA5, 1'b1},
        {1'b0, 7'd0, 8'h3C, 1'b1},
        {1'b1, 7'd0, 8'h3C, 1'b1},
        {1'b0, 7'd2, 8'h5A, 1'b1},
        {1'b1, 7'd2, 8'h5A, 1'b1},
        {1'b0, 7'd3, 8'h11, 1'b0},
        {1'b1, 7'd1, 8'hA5, 1'b1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * QTR) @(negedge clk);
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); b = sda_bus; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) wbit(b[i]);
        rbit(x);
        ack = ~x;
    endtask

    task automatic rbyte(output logic [7:0] b, input logic mack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            rbit(x);
            b[i] = x;
        end
        wbit(~mack);
    endtask

    task automatic byte_wr(input logic [6:0] off, input logic [7:0] dat,
                           output logic a_cmd, output logic a_dat);
        logic a;
        start_c();
        wbyte(8'hD2, a);
        wbyte({1'b1, off}, a_cmd);
        a_dat = 1'b0;
        if (a_cmd) wbyte(dat, a_dat);
        stop_c();
    endtask

    task automatic byte_rd(input logic [6:0] off, output logic [7:0] dat,
                           output logic acks);
        logic a0, a1, a2;
        start_c();
        wbyte(8'hD2, a0);
        wbyte({1'b1, off}, a1);
        start_c();
        wbyte(8'hD3, a2);
        rbyte(dat, 1'b0);
        stop_c();
        acks = a0 & a1 & a2;
    endtask

    // n data bytes taken from dat LSB first; ackmask bit i = ACK of data byte i
    task automatic blk_wr(input bit with_cnt, input logic [7:0] cnt, input int n,
                          input logic [31:0] dat, output logic hdr_ok,
                          output logic [3:0] ackmask);
        logic a0, a1, a2, a;
        start_c();
        wbyte(8'hD2, a0);
        wbyte(8'h00, a1);
        a2 = 1'b1;
        if (with_cnt) wbyte(cnt, a2);
        ackmask = 4'h0;
        for (int i = 0; i < n; i++) begin
            wbyte(dat[i*8 +: 8], a);
            ackmask[i] = a;
        end
        stop_c();
        hdr_ok = a0 & a1 & a2;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic       a, b, hok;
        logic [7:0] rd;
        logic [3:0] am;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk(regs == 24'hFEF7FF, "R1 reset registers", regs, 24'hFEF7FF);
        chk(sda_oe == 1'b0, "R1 SDA released at reset", sda_oe, 0);
        mdl = 24'hFEF7FF;

        // Vector walk: byte writes and byte reads (R3, R4, R5, R12)
        for (int v = 0; v < 11; v++) begin
            logic       is_rd, exp_ack;
            logic [6:0] off;
            logic [7:0] dat;
            {is_rd, off, dat, exp_ack} = VEC[v];
            if (is_rd) begin
                byte_rd(off, rd, a);
                chk(a == exp_ack, "R4 byte read acks", a, exp_ack);
                chk(rd == dat, "R4 byte read data", rd, dat);
            end else begin
                byte_wr(off, dat, a, b);
                if (exp_ack) begin
                    chk(a && b, "R3 byte write acks", {a, b}, 2'b11);
                    mdl[int'(off)*8 +: 8] = dat;
                    chk(regs[int'(off)*8 +: 8] == dat, "R12 register lane", regs, mdl);
                end else begin
                    chk(a == 1'b0, "R5 offset out of range NACK", a, 0);
                end
                chk(regs == mdl, "R3 register bank", regs, mdl);
            end
        end

        // R2: foreign address, following bytes ignored
        start_c();
        wbyte(8'hD4, a);
        chk(!a, "R2 foreign address NACK", a, 0);
        wbyte(8'h81, a);
        chk(!a, "R2 command after foreign address", a, 0);
        wbyte(8'h00, a);
        chk(!a, "R2 data after foreign address", a, 0);
        stop_c();
        chk(regs == mdl, "R2 registers untouched", regs, mdl);

        // R6: block write with count byte
        blk_wr(1'b1, 8'h03, 3, 32'h00_32_22_11, hok, am);
        chk(hok && am == 4'b0111, "R6 block write acks", {hok, am}, 5'h17);
        mdl = 24'h32_22_11;
        chk(regs == mdl, "R6 block write order", regs, mdl);

        // R6: early stop after one data byte
        blk_wr(1'b1, 8'h03, 1, 32'h0000_0077, hok, am);
        mdl = 24'h32_22_77;
        chk(regs == mdl, "R6 early stop keeps rest", regs, mdl);

        // R10: data past the last register
        blk_wr(1'b1, 8'h04, 4, 32'hD5_C4_B2_A1, hok, am);
        chk(am == 4'b0111, "R10 overflow byte NACK", am, 4'b0111);
        mdl = 24'hC4_B2_A1;
        chk(regs == mdl, "R10 overflow not stored", regs, mdl);

        // R9: block command with nonzero low bits
        start_c();
        wbyte(8'hD2, a);
        wbyte(8'h05, b);
        stop_c();
        chk(a && !b, "R9 malformed block command NACK", {a, b}, 2'b10);
        chk(regs == mdl, "R9 registers untouched", regs, mdl);

        // R8: block read
        start_c();
        wbyte(8'hD2, a);
        wbyte(8'h00, b);
        start_c();
        wbyte(8'hD3, hok);
        chk(a && b && hok, "R8 block read header acks", {a, b, hok}, 3'b111);
        rbyte(rd, 1'b1);
        chk(rd == 8'h03, "R8 count byte", rd, 8'h03);
        rbyte(rd, 1'b1);
        chk(rd == 8'hA1, "R8 register 0", rd, 8'hA1);
        rbyte(rd, 1'b1);
        chk(rd == 8'hB2, "R8 register 1", rd, 8'hB2);
        rbyte(rd, 1'b0);
        chk(rd == 8'hC4, "R8 register 2", rd, 8'hC4);
        chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
        stop_c();
        chk(sda_oe == 1'b0 && sda_bus == 1'b1, "R11 idle after stop", sda_bus, 1);

        // R7: count byte removed while regs_o[16] is set
        byte_wr(7'd2, 8'hC5, a, b);
        mdl = 24'hC5_B2_A1;
        chk(regs == mdl, "R7 control bit set", regs, mdl);
        blk_wr(1'b0, 8'h00, 2, 32'h0000_6B_5A, hok, am);
        chk(hok && am == 4'b0011, "R7 block write acks", {hok, am}, 5'h13);
        mdl = 24'hC5_6B_5A;
        chk(regs == mdl, "R7 first byte to register 0", regs, mdl);
        byte_wr(7'd2, 8'h00, a, b);
        blk_wr(1'b1, 8'h01, 1, 32'h0000_0099, hok, am);
        mdl = 24'h00_6B_99;
        chk(regs == mdl, "R7 count byte back when bit clear", regs, mdl);

        // R11: stop in the middle of the address byte
        start_c();
        wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b1);
        stop_c();
        chk(sda_oe == 1'b0, "R11 released after aborted byte", sda_oe, 0);
        byte_rd(7'd1, rd, a);
        chk(a && rd == 8'h6B, "R11 recovery read", rd, 8'h6B);

        // R5: byte read with out-of-range offset
        start_c();
        wbyte(8'hD2, a);
        wbyte(8'h83, b);
        stop_c();
        chk(!b, "R5 read offset out of range NACK", b, 0);
        chk(regs == mdl, "R5 registers untouched", regs, mdl);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule